// File: doc/BRIEF.md
# Delayed Line-Voltage Current Reference Generator

This block produces the current-loop reference for a digital boost power-factor-correction controller. Each sample tick brings a signed 12-bit line-voltage sample. The sample goes into a 128-entry circular history. An older entry is read back, and that entry is multiplied by the voltage-loop output and by the reciprocal of the squared RMS line voltage. Because the reference follows a lagged copy of the line, the inductor current lags the line voltage. This offsets the leading reactive current drawn by the input filter capacitance.

The number of samples of lag comes from a 4 by 4 table of 7-bit entries. One index is a binned line-RMS level and the other is a binned load level. Firmware fills the table through a write port. Entries should give a shorter lag at low line and at heavy load. Near a zero crossing the lagged voltage can have the opposite sign from the present line. In that case the rectifier bridge could not conduct, so the block forces the reference to exactly zero. This keeps the current-loop integrator from winding up.

Top module: `pfc_iref_delay`

## Requirements
- R1: While reset is asserted and after it is released, `ref_o` and `ref_valid_o` are 0 until a result is produced. `ref_o` is 0 in every cycle where `ref_valid_o` is low.
- R2: Every `sample_valid_i` strobe yields exactly one `ref_valid_o` pulse. The pulse is high in the cycle after the third rising edge counted from the edge that captured the strobe. No pulse appears without a strobe, and results come out in strobe order.
- R3: The result is `min(65535, floor((A*B*|C| + 2^25) / 2^26))`. A is `vloop_i` and B is `inv_rms2_i`, both unsigned Q1.15 raw values. C is the selected history sample, read as two's complement.
- R4: A lag of d selects the sample strobed d strobes before the current one. A lag of 0 selects the current sample itself.
- R5: The lag is table entry `{line_rms_i[15:14], load_i[15:14]}`, that is, RMS bin in address bits 3:2 and load bin in bits 1:0. An entry is written with `tbl_data_i` at the rising edge where `tbl_we_i` is high. All entries reset to 0.
- R6: When the sign bit (bit 11) of the current sample differs from the sign bit of the selected sample, the result is exactly 0 and is still marked valid.
- R7: When fewer than d samples have been stored since reset before the current one, the result is 0.
- R8: A, B, the RMS level and the load level are taken in the cycle of the strobe. Changes to them between strobes have no effect on results.
- R9: The history wraps after 128 samples. A lag of 127 still returns the correct older sample after many more than 128 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_valid_i | input | 1 | Single-cycle sample strobe |
| sample_i | input | 12 | Signed line-voltage sample |
| vloop_i | input | 16 | Voltage-loop output, unsigned Q1.15 |
| inv_rms2_i | input | 16 | Reciprocal squared RMS line voltage, unsigned Q1.15 |
| line_rms_i | input | 16 | Unsigned line RMS level, top 2 bits used as bin |
| load_i | input | 16 | Unsigned load level, top 2 bits used as bin |
| tbl_we_i | input | 1 | Lag table write enable |
| tbl_addr_i | input | 4 | Lag table address {rms bin, load bin} |
| tbl_data_i | input | 7 | Lag table entry in samples |
| ref_o | output | 16 | Unsigned current reference |
| ref_valid_o | output | 1 | Reference valid pulse |

## Verification
The bench runs a sampled sine through several lag settings so that each zero crossing lands in a window where the present and lagged signs disagree. A design that did not blank there would emit a nonzero reference where the expected value is zero. The bench also targets lag 0, where a design reading the memory instead of the incoming sample would return a value 128 samples old, and lag 127 after wraparound, where an off-by-one pointer would pick a neighbour. Right after reset it applies a nonzero lag, so a design without the fill guard would multiply stale or cleared history. Products near full scale and odd Q1.15 operands expose missing saturation and wrong rounding. The bench also changes A and B between strobes, which exposes a design that samples those terms late.

// File: rtl/pfc_iref_pkg.sv
package pfc_iref_pkg;
  localparam int unsigned SMP_W  = 12;
  localparam int unsigned DEPTH  = 128;
  localparam int unsigned Q_W    = 16;
  localparam int unsigned REF_W  = 16;
  localparam int unsigned BIN_W  = 2;
  localparam int unsigned LVL_W  = 16;
  localparam int unsigned SHIFT  = 26;
endpackage

// File: rtl/pfc_hist_buf.sv
module pfc_hist_buf #(
  parameter int unsigned SMP_W = 12,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SMP_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0] dly_i,
  output logic [SMP_W-1:0] rd_data_o,
  output logic             enough_o
);
  logic [SMP_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, fill, rd_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      fill <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (wr_en_i) begin
      mem[wptr] <= wr_data_i;
      wptr      <= wptr + 1'b1;
      if (fill != '1) fill <= fill + 1'b1;  // saturates at DEPTH-1, enough for max lag
    end
  end

  assign rd_idx    = wptr - dly_i;
  assign rd_data_o = (dly_i == '0) ? wr_data_i : mem[rd_idx];
  assign enough_o  = fill >= dly_i;

  AST_FILL_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> fill >= $past(fill)); // R7
  AST_WPTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wptr)); // R4
endmodule

// File: rtl/pfc_delay_lut.sv
module pfc_delay_lut #(
  parameter int unsigned BIN_W = 2,
  parameter int unsigned DLY_W = 7,
  localparam int unsigned ADR_W = 2 * BIN_W,
  localparam int unsigned LUT_N = 1 << ADR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ADR_W-1:0] waddr_i,
  input  logic [DLY_W-1:0] wdata_i,
  input  logic [BIN_W-1:0] rms_bin_i,
  input  logic [BIN_W-1:0] load_bin_i,
  output logic [DLY_W-1:0] dly_o
);
  logic [DLY_W-1:0] tbl [LUT_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(LUT_N); i++) tbl[i] <= '0;
    end else if (we_i) begin
      tbl[waddr_i] <= wdata_i;
    end
  end

  assign dly_o = tbl[{rms_bin_i, load_bin_i}];

  AST_TBL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tbl[$past(waddr_i)] == $past(wdata_i)); // R5
endmodule

// File: rtl/pfc_ref_mult.sv
module pfc_ref_mult #(
  parameter int unsigned SMP_W = 12,
  parameter int unsigned Q_W   = 16,
  parameter int unsigned REF_W = 16,
  parameter int unsigned SHIFT = 26,
  localparam int unsigned AB_W   = 2 * Q_W,
  localparam int unsigned PROD_W = AB_W + SMP_W,
  localparam int unsigned SH_W   = PROD_W + 1 - SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [Q_W-1:0]   a_i,
  input  logic [Q_W-1:0]   b_i,
  input  logic [SMP_W-1:0] c_i,
  input  logic             keep_i,
  output logic [REF_W-1:0] ref_o,
  output logic             vld_o
);
  localparam logic [PROD_W:0] HALF = (PROD_W+1)'(1) << (SHIFT - 1);

  logic [AB_W-1:0]   s2_ab;
  logic [SMP_W-1:0]  s2_mag, mag;
  logic              s2_vld, s2_keep;
  logic [PROD_W-1:0] full;
  logic [PROD_W:0]   rnd;
  logic [SH_W-1:0]   shifted;
  logic [REF_W-1:0]  sat;
  logic              unused_rnd;

  assign mag = c_i[SMP_W-1] ? (~c_i + 1'b1) : c_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_ab <= '0; s2_mag <= '0; s2_vld <= 1'b0; s2_keep <= 1'b0;
    end else begin
      s2_vld <= vld_i;
      if (vld_i) begin
        s2_ab   <= a_i * b_i;
        s2_mag  <= mag;
        s2_keep <= keep_i;
      end
    end
  end

  assign full       = PROD_W'(s2_ab) * PROD_W'(s2_mag);
  assign rnd        = {1'b0, full} + HALF;
  assign shifted    = rnd[PROD_W:SHIFT];
  assign unused_rnd = ^rnd[SHIFT-1:0];
  assign sat        = (|shifted[SH_W-1:REF_W]) ? '1 : shifted[REF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o <= '0; vld_o <= 1'b0;
    end else begin
      vld_o <= s2_vld;
      ref_o <= (s2_vld && s2_keep) ? sat : '0;
    end
  end

  AST_BLANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_vld && !s2_keep) |=> ref_o == '0); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> ref_o == '0); // R1
  AST_ZERO_MAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_vld && (s2_ab == '0 || s2_mag == '0)) |=> ref_o == '0); // R3
endmodule

// File: rtl/pfc_iref_delay.sv
module pfc_iref_delay
  import pfc_iref_pkg::*;
#(
  parameter int unsigned P_SMP_W = SMP_W,
  parameter int unsigned P_DEPTH = DEPTH,
  parameter int unsigned P_Q_W   = Q_W,
  parameter int unsigned P_REF_W = REF_W,
  parameter int unsigned P_BIN_W = BIN_W,
  parameter int unsigned P_LVL_W = LVL_W,
  localparam int unsigned PTR_W  = $clog2(P_DEPTH),
  localparam int unsigned ADR_W  = 2 * P_BIN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_valid_i,
  input  logic [P_SMP_W-1:0] sample_i,
  input  logic [P_Q_W-1:0]   vloop_i,
  input  logic [P_Q_W-1:0]   inv_rms2_i,
  input  logic [P_LVL_W-1:0] line_rms_i,
  input  logic [P_LVL_W-1:0] load_i,
  input  logic               tbl_we_i,
  input  logic [ADR_W-1:0]   tbl_addr_i,
  input  logic [PTR_W-1:0]   tbl_data_i,
  output logic [P_REF_W-1:0] ref_o,
  output logic               ref_valid_o
);
  logic [PTR_W-1:0]   dly;
  logic [P_SMP_W-1:0] hist_c;
  logic               enough, sign_ok;
  logic               s1_vld, s1_keep;
  logic [P_Q_W-1:0]   s1_a, s1_b;
  logic [P_SMP_W-1:0] s1_c;
  logic               unused_lvl;

  assign unused_lvl = ^{line_rms_i[P_LVL_W-P_BIN_W-1:0], load_i[P_LVL_W-P_BIN_W-1:0]};

  pfc_delay_lut #(.BIN_W(P_BIN_W), .DLY_W(PTR_W)) u_lut (
    .clk_i, .rst_ni,
    .we_i       (tbl_we_i),
    .waddr_i    (tbl_addr_i),
    .wdata_i    (tbl_data_i),
    .rms_bin_i  (line_rms_i[P_LVL_W-1 -: P_BIN_W]),
    .load_bin_i (load_i[P_LVL_W-1 -: P_BIN_W]),
    .dly_o      (dly)
  );

  pfc_hist_buf #(.SMP_W(P_SMP_W), .DEPTH(P_DEPTH)) u_hist (
    .clk_i, .rst_ni,
    .wr_en_i   (sample_valid_i),
    .wr_data_i (sample_i),
    .dly_i     (dly),
    .rd_data_o (hist_c),
    .enough_o  (enough)
  );

  // rectifier cannot conduct against the line: blank on sign disagreement
  assign sign_ok = sample_i[P_SMP_W-1] == hist_c[P_SMP_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0; s1_keep <= 1'b0;
      s1_a <= '0; s1_b <= '0; s1_c <= '0;
    end else begin
      s1_vld <= sample_valid_i;
      if (sample_valid_i) begin
        s1_a    <= vloop_i;
        s1_b    <= inv_rms2_i;
        s1_c    <= hist_c;
        s1_keep <= enough && sign_ok;
      end
    end
  end

  pfc_ref_mult #(.SMP_W(P_SMP_W), .Q_W(P_Q_W), .REF_W(P_REF_W), .SHIFT(SHIFT)) u_mult (
    .clk_i, .rst_ni,
    .vld_i  (s1_vld),
    .a_i    (s1_a),
    .b_i    (s1_b),
    .c_i    (s1_c),
    .keep_i (s1_keep),
    .ref_o  (ref_o),
    .vld_o  (ref_valid_o)
  );

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |-> ##3 ref_valid_o); // R2
  AST_VALID_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_o |-> $past(sample_valid_i, 3)); // R2
  AST_UNFILLED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !enough) |-> ##3 ref_o == '0); // R7
endmodule

// File: tb/pfc_iref_delay_tb_top.sv
`timescale 1ns/1ps
module pfc_iref_delay_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic [15:0] vloop_i = '0, inv_rms2_i = '0, line_rms_i = '0, load_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [3:0]  tbl_addr_i = '0;
  logic [6:0]  tbl_data_i = '0;
  logic [15:0] ref_o;
  logic        ref_valid_o;

  pfc_iref_delay dut_i (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0, nhist = 0;
  int hist [4096];
  int tblm [16];
  int exp_q[$];
  int cyc_q[$];
  string tag_q[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int calc_ref(input int a, input int b, input int c);
    longint p, r;
    int m;
    m = (c < 0) ? -c : c;
    p = longint'(a) * longint'(b) * longint'(m);
    r = (p + (64'sd1 <<< 25)) >>> 26;
    if (r > 65535) r = 65535;
    return int'(r);
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    nhist = 0;
    for (int i = 0; i < 16; i++) tblm[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic tbl_write(input int addr, input int d);
    tbl_we_i = 1'b1; tbl_addr_i = 4'(addr); tbl_data_i = 7'(d);
    @(negedge clk_i);
    tbl_we_i = 1'b0;
    tblm[addr] = d;
  endtask

  task automatic push_sample(input int s, input int a, input int b,
                             input int rms, input int load, input string tag);
    int d, c, e;
    d = tblm[{rms[15:14], load[15:14]}];
    c = (d == 0) ? s : hist[(nhist - d) & 4095];
    if (nhist < d) e = 0;
    else if ((s < 0) != (c < 0)) e = 0;
    else e = calc_ref(a, b, c);
    hist[nhist & 4095] = s;
    nhist++;
    sample_i = 12'(s); vloop_i = 16'(a); inv_rms2_i = 16'(b);
    line_rms_i = 16'(rms); load_i = 16'(load); sample_valid_i = 1'b1;
    exp_q.push_back(e); cyc_q.push_back(cyc + 3); tag_q.push_back(tag);
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  // R8: disturb sampled terms between strobes
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      vloop_i = 16'($urandom); inv_rms2_i = 16'($urandom);
      line_rms_i = 16'($urandom); load_i = 16'($urandom);
      @(negedge clk_i);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && ref_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected valid", 1, 0);
      end else begin
        int e, ec;
        string t;
        e = exp_q.pop_front(); ec = cyc_q.pop_front(); t = tag_q.pop_front();
        chk(int'(ref_o) == e, t, int'(ref_o), e);
        chk(cyc == ec, "R2 latency", cyc, ec);
      end
    end else if (rst_ni) begin
      if (ref_o != 16'd0) chk(1'b0, "R1 idle output", int'(ref_o), 0);
    end
  end

  function automatic int sine(input int i, input int per, input int amp);
    return $rtoi(amp * $sin(2.0 * 3.14159265358979 * i / per));
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(ref_o == 16'd0, "R1 reset ref", int'(ref_o), 0);
    chk(ref_valid_o == 1'b0, "R1 reset valid", int'(ref_valid_o), 0);
    do_reset();
    chk(ref_o == 16'd0, "R1 after reset ref", int'(ref_o), 0);

    // lag 0, unity gains, back-to-back strobes
    for (int i = 0; i < 40; i++) push_sample(sine(i, 40, 2000), 16'h8000, 16'h8000, 0, 0, "R4 R3 lag0");
    idle(4);
    // rounding with odd operands, and saturation
    for (int i = 0; i < 20; i++) begin
      push_sample(int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 65535)),
                  int'($urandom_range(0, 65535)), 0, 0, "R3 round");
      idle(1);
    end
    push_sample(-2048, 16'hFFFF, 16'hFFFF, 0, 0, "R3 sat neg");
    push_sample(2047, 16'hFFFF, 16'hFFFF, 0, 0, "R3 sat pos");
    push_sample(0, 16'hFFFF, 16'hFFFF, 0, 0, "R3 zero");
    idle(4);

    // shorter lag at low line and heavy load
    for (int r = 0; r < 4; r++)
      for (int l = 0; l < 4; l++) tbl_write(r * 4 + l, 8 + 8 * r + 8 * (3 - l));
    for (int i = 0; i < 320; i++) begin
      int rb, lb;
      rb = (i / 80) % 4; lb = (i / 20) % 4;
      push_sample(sine(i, 64, 1900), 16'h6000 + i, 16'h9000 - i,
                  (rb << 14) | (i & 16'h3FFF), (lb << 14) | 16'h0123, "R4 R5 R6 R8");
      if (i % 3 == 0) idle(1);
    end
    idle(4);

    // wraparound at maximum lag
    tbl_write(15, 127);
    for (int i = 0; i < 300; i++)
      push_sample(sine(i, 50, 1500) + (i % 7), 16'h8000, 16'h7000, 16'hFFFF, 16'hFFFF, "R9 wrap");
    idle(4);
    chk(exp_q.size() == 0, "R2 drained", exp_q.size(), 0);

    // fill guard after reset
    do_reset();
    tbl_write(0, 5);
    for (int i = 0; i < 9; i++) push_sample(100 + 50 * i, 16'h8000, 16'h8000, 0, 0, "R7 fill");
    idle(5);
    chk(exp_q.size() == 0, "R2 drained end", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule